// File: doc/BRIEF.md
# Banked processor status register

This block keeps the 32-bit status word of a processor core and the control logic that reads it directly. The word holds a privilege mode, a bank selector for the low general registers, an event-block flag, an FPU-off flag, the two divide-step flags, a four-bit interrupt threshold, a saturation flag and the condition flag. Software writes the word through a register port. An exception or interrupt entry event forces the privilege, bank and block bits high, and reset loads a fixed value.

The block also holds two physical banks of eight 32-bit registers that back the architectural R0–R7. The main port reaches the bank the status word selects. A second port, usable only in privileged mode, reaches the other bank. Combinational outputs tell the core whether a pending interrupt is taken, whether a general exception must escalate to reset, and whether an FPU instruction must trap. The FPU trap comes in a normal variant and a delay-slot variant.

Top module: `psw_ctrl`

## Requirements
- R1: In privileged mode, a write stores the data masked to the defined fields, and the word reads back that value from the next cycle on. The defined fields are bit 30 (mode, 1 = privileged), bit 29 (bank select), bit 28 (block), bit 15 (FPU off), bits 9 and 8 (divide-step flags), bits 7:4 (interrupt threshold), bit 1 (saturate) and bit 0 (condition), which gives a write mask of 0x700083F3.
- R2: Every bit outside the 0x700083F3 mask always reads 0, whatever is written.
- R3: After reset the word reads 0x700000F0: mode, bank select and block are 1, the threshold is 1111, and every other bit is 0. Both register banks are cleared to 0.
- R4: An entry event sets bits 30, 29 and 28 to 1 on the next edge and leaves all other bits unchanged, including the threshold. When an entry event and a write occur in the same cycle, the entry event takes effect and the write is dropped.
- R5: The main register port uses bank (mode AND bank select). In user mode it always uses bank 0.
- R6: In privileged mode the alternate port reads and writes the bank that the main port is not using. In user mode, alternate-port writes are ignored and alternate reads return 0.
- R7: While block = 1, no interrupt is accepted.
- R8: An interrupt is accepted exactly when a request is present, block = 0, and the request level is strictly greater than the threshold. A level equal to the threshold is not accepted.
- R9: The reset request is high exactly when a general exception (other than a user break) is presented while block = 1.
- R10: With FPU off = 1, an FPU instruction raises the normal FPU trap when it is outside a delay slot and the slot trap when it is inside one. The two traps are never raised together, and neither is raised when FPU off = 0.
- R11: In user mode a status write leaves the word unchanged, and the privilege-violation output is high in the cycle of the write. A write in privileged mode does not raise it.
- R12: A main-port write to register i is visible on the main read data from the next cycle on. Reads are combinational on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wdata | input | 32 | Status word write data |
| sr_rdata | output | 32 | Current status word |
| sr_priv_viol | output | 1 | Status write attempted in user mode |
| entry_evt | input | 1 | Exception or interrupt entry event |
| irq_req | input | 1 | Interrupt request pending |
| irq_level | input | 4 | Level of the pending request |
| irq_accept | output | 1 | Pending request is taken |
| gen_exc | input | 1 | General exception (not user break) presented |
| reset_req | output | 1 | Escalate to reset (exception while blocked) |
| fpu_insn | input | 1 | Current instruction is an FPU instruction |
| fpu_in_slot | input | 1 | Current instruction sits in a delay slot |
| fpu_dis_exc | output | 1 | FPU-off trap, normal variant |
| fpu_slot_exc | output | 1 | FPU-off trap, delay-slot variant |
| gpr_we | input | 1 | Main register port write enable |
| gpr_idx | input | 3 | Main register port index (R0–R7) |
| gpr_wdata | input | 32 | Main register port write data |
| gpr_rdata | output | 32 | Main register port read data |
| alt_we | input | 1 | Alternate-bank port write enable |
| alt_idx | input | 3 | Alternate-bank port index |
| alt_wdata | input | 32 | Alternate-bank port write data |
| alt_rdata | output | 32 | Alternate-bank port read data |

## Verification
The bench sweeps every threshold against every request level, with block both clear and set. A comparator that used greater-or-equal, or ignored the block bit, would accept a request at the threshold or while blocked. It fills both banks with distinct values and then flips the bank select and drops into user mode. Steering that ignored the mode bit would expose bank 1 in user mode, and a user-mode alternate write that was not gated would corrupt a bank 1 value, which the bench reads back after an entry event. It also collides an entry event with a write and tries status writes in user mode. Wrong priority or a missing privilege gate would show as a changed threshold or a changed word.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned PSW_W      = 32;
  localparam int unsigned POS_MODE   = 30;
  localparam int unsigned POS_BANK   = 29;
  localparam int unsigned POS_BLOCK  = 28;
  localparam int unsigned POS_FPOFF  = 15;
  localparam int unsigned POS_DM     = 9;
  localparam int unsigned POS_DQ     = 8;
  localparam int unsigned POS_THR    = 4;
  localparam int unsigned THR_W      = 4;
  localparam int unsigned POS_SAT    = 1;
  localparam int unsigned POS_COND   = 0;

  function automatic logic [PSW_W-1:0] rw_mask();
    logic [PSW_W-1:0] m;
    m = '0;
    m[POS_MODE]  = 1'b1;
    m[POS_BANK]  = 1'b1;
    m[POS_BLOCK] = 1'b1;
    m[POS_FPOFF] = 1'b1;
    m[POS_DM]    = 1'b1;
    m[POS_DQ]    = 1'b1;
    m[POS_THR +: THR_W] = '1;
    m[POS_SAT]   = 1'b1;
    m[POS_COND]  = 1'b1;
    return m;
  endfunction

  function automatic logic [PSW_W-1:0] reset_word();
    logic [PSW_W-1:0] r;
    r = '0;
    r[POS_MODE]  = 1'b1;
    r[POS_BANK]  = 1'b1;
    r[POS_BLOCK] = 1'b1;
    r[POS_THR +: THR_W] = '1;
    return r;
  endfunction

  function automatic logic [PSW_W-1:0] entry_set();
    logic [PSW_W-1:0] e;
    e = '0;
    e[POS_MODE]  = 1'b1;
    e[POS_BANK]  = 1'b1;
    e[POS_BLOCK] = 1'b1;
    return e;
  endfunction

  // Interrupt taken: not blocked and strictly above the threshold.
  function automatic logic irq_takes(input logic req, input logic blk,
                                     input logic [THR_W-1:0] lvl,
                                     input logic [THR_W-1:0] thr);
    return req & ~blk & (lvl > thr);
  endfunction

  // Physical bank used by the main port.
  function automatic logic active_bank(input logic mode, input logic bsel);
    return mode & bsel;
  endfunction
endpackage

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSW_W-1:0] wr_data,
  input  logic             entry_evt,
  output logic [PSW_W-1:0] psw_q,
  output logic             wr_reject
);
  localparam logic [PSW_W-1:0] MASK  = rw_mask();
  localparam logic [PSW_W-1:0] RST   = reset_word();
  localparam logic [PSW_W-1:0] ENTRY = entry_set();

  logic priv;
  assign priv      = psw_q[POS_MODE];
  assign wr_reject = wr_en & ~priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              psw_q <= RST;
    else if (entry_evt)      psw_q <= psw_q | ENTRY;
    else if (wr_en && priv)  psw_q <= wr_data & MASK;
  end
endmodule

// File: rtl/psw_events.sv
module psw_events
  import psw_pkg::*;
(
  input  logic             blk,
  input  logic             fpoff,
  input  logic [THR_W-1:0] thr,
  input  logic             irq_req,
  input  logic [THR_W-1:0] irq_level,
  input  logic             gen_exc,
  input  logic             fpu_insn,
  input  logic             fpu_in_slot,
  output logic             irq_accept,
  output logic             reset_req,
  output logic             fpu_dis_exc,
  output logic             fpu_slot_exc
);
  logic fpu_trap;
  assign irq_accept   = irq_takes(irq_req, blk, irq_level, thr);
  assign reset_req    = gen_exc & blk;
  assign fpu_trap     = fpu_insn & fpoff;
  assign fpu_dis_exc  = fpu_trap & ~fpu_in_slot;
  assign fpu_slot_exc = fpu_trap & fpu_in_slot;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr_en,
  input  logic [PSW_W-1:0]  sr_wdata,
  output logic [PSW_W-1:0]  sr_rdata,
  output logic              sr_priv_viol,
  input  logic              entry_evt,
  input  logic              irq_req,
  input  logic [THR_W-1:0]  irq_level,
  output logic              irq_accept,
  input  logic              gen_exc,
  output logic              reset_req,
  input  logic              fpu_insn,
  input  logic              fpu_in_slot,
  output logic              fpu_dis_exc,
  output logic              fpu_slot_exc,
  input  logic              gpr_we,
  input  logic [IDX_W-1:0]  gpr_idx,
  input  logic [DATA_W-1:0] gpr_wdata,
  output logic [DATA_W-1:0] gpr_rdata,
  input  logic              alt_we,
  input  logic [IDX_W-1:0]  alt_idx,
  input  logic [DATA_W-1:0] alt_wdata,
  output logic [DATA_W-1:0] alt_rdata
);
  logic [PSW_W-1:0] psw_q;
  logic             priv;
  logic             act_bank;
  logic [DATA_W-1:0] bank_rd [2];

  psw_reg u_psw (
    .clk, .rst_n,
    .wr_en     (sr_wr_en),
    .wr_data   (sr_wdata),
    .entry_evt (entry_evt),
    .psw_q     (psw_q),
    .wr_reject (sr_priv_viol)
  );

  psw_events u_evt (
    .blk         (psw_q[POS_BLOCK]),
    .fpoff       (psw_q[POS_FPOFF]),
    .thr         (psw_q[POS_THR +: THR_W]),
    .irq_req, .irq_level, .gen_exc, .fpu_insn, .fpu_in_slot,
    .irq_accept, .reset_req, .fpu_dis_exc, .fpu_slot_exc
  );

  assign priv     = psw_q[POS_MODE];
  assign act_bank = active_bank(priv, psw_q[POS_BANK]);
  assign sr_rdata = psw_q;

  // Each physical bank serves either the main port or the alternate port.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              is_act;
    logic              b_we;
    logic [IDX_W-1:0]  b_idx;
    logic [DATA_W-1:0] b_wd;
    assign is_act = (act_bank == 1'(b));
    assign b_we   = is_act ? gpr_we    : (alt_we & priv);
    assign b_idx  = is_act ? gpr_idx   : alt_idx;
    assign b_wd   = is_act ? gpr_wdata : alt_wdata;
    gpr_bank #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
      .clk, .rst_n,
      .we    (b_we),
      .idx   (b_idx),
      .wdata (b_wd),
      .rdata (bank_rd[b])
    );
  end

  assign gpr_rdata = bank_rd[act_bank];
  assign alt_rdata = priv ? bank_rd[~act_bank] : '0;
endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_wr_en,
  input logic [PSW_W-1:0]  sr_rdata,
  input logic              sr_priv_viol,
  input logic              entry_evt,
  input logic              irq_req,
  input logic [THR_W-1:0]  irq_level,
  input logic              irq_accept,
  input logic              gen_exc,
  input logic              reset_req,
  input logic              fpu_dis_exc,
  input logic              fpu_slot_exc,
  input logic [DATA_W-1:0] alt_rdata
);
  localparam logic [PSW_W-1:0] MASK = rw_mask();
  localparam logic [PSW_W-1:0] RST  = reset_word();

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata & ~MASK) == '0);

  p_reset_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sr_rdata == RST);

  p_entry_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> (sr_rdata[POS_BLOCK +: 3] == 3'b111) &&
                  (sr_rdata[POS_THR +: THR_W] == $past(sr_rdata[POS_THR +: THR_W])));

  p_alt_user_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_rdata[POS_MODE] |-> alt_rdata == '0);

  p_block_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rdata[POS_BLOCK] |-> !irq_accept);

  p_accept_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> irq_req && (irq_level > sr_rdata[POS_THR +: THR_W]));

  p_double_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_exc && sr_rdata[POS_BLOCK]) |-> reset_req);

  p_fpu_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fpu_dis_exc, fpu_slot_exc}));

  p_user_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && !sr_rdata[POS_MODE] && !entry_evt) |-> sr_priv_viol ##1 $stable(sr_rdata));
endmodule

bind psw_ctrl psw_ctrl_chk #(.DATA_W(DATA_W)) i_psw_chk (
  .clk, .rst_n, .sr_wr_en, .sr_rdata, .sr_priv_viol, .entry_evt,
  .irq_req, .irq_level, .irq_accept, .gen_exc, .reset_req,
  .fpu_dis_exc, .fpu_slot_exc, .alt_rdata
);

// File: tb/test_psw_ctrl.sv
module test_psw_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        sr_priv_viol;
  logic        entry_evt = 1'b0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_level = '0;
  logic        irq_accept;
  logic        gen_exc = 1'b0;
  logic        reset_req;
  logic        fpu_insn = 1'b0;
  logic        fpu_in_slot = 1'b0;
  logic        fpu_dis_exc;
  logic        fpu_slot_exc;
  logic        gpr_we = 1'b0;
  logic [2:0]  gpr_idx = '0;
  logic [31:0] gpr_wdata = '0;
  logic [31:0] gpr_rdata;
  logic        alt_we = 1'b0;
  logic [2:0]  alt_idx = '0;
  logic [31:0] alt_wdata = '0;
  logic [31:0] alt_rdata;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // Field mask built from the bit list of R1.
  localparam logic [31:0] FIELDS = (32'd1 << 30) | (32'd1 << 29) | (32'd1 << 28) |
                                   (32'd1 << 15) | (32'd3 << 8) | (32'hF << 4) | 32'd3;

  always #10 clk = ~clk;

  psw_ctrl i_psw_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic write_sr(input logic [31:0] v);
    sr_wr_en = 1'b1;
    sr_wdata = v;
    tick();
    sr_wr_en = 1'b0;
    #1;
  endtask

  task automatic write_gpr(input int i, input logic [31:0] v);
    gpr_we = 1'b1;
    gpr_idx = 3'(i);
    gpr_wdata = v;
    tick();
    gpr_we = 1'b0;
    #1;
  endtask

  task automatic pulse_entry();
    entry_evt = 1'b1;
    tick();
    entry_evt = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R3: reset word and cleared banks
    check("R3", sr_rdata, 32'h700000F0);
    check("R3", gpr_rdata, 32'h0);

    // R1 / R2: masked write and readback, privileged mode kept
    for (int i = 0; i < 10; i++) begin
      logic [31:0] p;
      p = (32'(i) * 32'h9E3779B9) ^ 32'hA5C3_0F17;
      p[30] = 1'b1;
      if (i == 0) p = 32'hFFFFFFFF;
      write_sr(p);
      check("R1", sr_rdata, p & FIELDS);
      check("R2", sr_rdata & ~FIELDS, 32'h0);
    end

    // R7 / R8: full sweep of block, threshold, level and request
    for (int bl = 0; bl < 2; bl++) begin
      for (int th = 0; th < 16; th++) begin
        write_sr((32'd1 << 30) | (32'(bl) << 28) | (32'(th) << 4));
        for (int lv = 0; lv < 16; lv++) begin
          for (int rq = 0; rq < 2; rq++) begin
            irq_level = 4'(lv);
            irq_req = rq[0];
            #1;
            if (bl == 1) check("R7", {31'd0, irq_accept}, 32'd0);
            else check("R8", {31'd0, irq_accept}, {31'd0, (rq == 1 && lv > th)});
          end
        end
      end
    end
    irq_req = 1'b0;

    // R9: escalation only while blocked
    for (int bl = 0; bl < 2; bl++) begin
      write_sr((32'd1 << 30) | (32'(bl) << 28));
      for (int g = 0; g < 2; g++) begin
        gen_exc = g[0];
        #1;
        check("R9", {31'd0, reset_req}, {31'd0, (g == 1 && bl == 1)});
      end
    end
    gen_exc = 1'b0;

    // R10: FPU trap variants
    for (int fd = 0; fd < 2; fd++) begin
      write_sr((32'd1 << 30) | (32'(fd) << 15));
      for (int ins = 0; ins < 2; ins++) begin
        for (int sl = 0; sl < 2; sl++) begin
          fpu_insn = ins[0];
          fpu_in_slot = sl[0];
          #1;
          check("R10", {30'd0, fpu_slot_exc, fpu_dis_exc},
                {30'd0, (fd == 1 && ins == 1 && sl == 1), (fd == 1 && ins == 1 && sl == 0)});
        end
      end
    end
    fpu_insn = 1'b0;
    fpu_in_slot = 1'b0;

    // R4: entry forces mode/bank/block, threshold kept
    write_sr(32'h400000A3);
    sr_wr_en = 1'b1;
    #1;
    check("R11", {31'd0, sr_priv_viol}, 32'd0);
    sr_wr_en = 1'b0;
    pulse_entry();
    check("R4", sr_rdata, 32'h700000A3);
    // R4: entry wins over a simultaneous write
    write_sr(32'h400000A3);
    sr_wr_en = 1'b1;
    sr_wdata = 32'h40000050;
    pulse_entry();
    sr_wr_en = 1'b0;
    #1;
    check("R4", sr_rdata, 32'h700000A3);

    // R5 / R6 / R12: fill both banks and steer
    write_sr(32'h40000000);
    for (int i = 0; i < 8; i++) begin
      write_gpr(i, 32'h1000 + 32'(i));
      check("R12", gpr_rdata, 32'h1000 + 32'(i));
    end
    write_sr(32'h60000000);
    for (int i = 0; i < 8; i++) write_gpr(i, 32'h2000 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      gpr_idx = 3'(i);
      alt_idx = 3'(i);
      #1;
      check("R5", gpr_rdata, 32'h2000 + 32'(i));
      check("R6", alt_rdata, 32'h1000 + 32'(i));
    end
    write_sr(32'h40000000);
    for (int i = 0; i < 8; i++) begin
      gpr_idx = 3'(i);
      alt_idx = 3'(i);
      #1;
      check("R5", gpr_rdata, 32'h1000 + 32'(i));
      check("R6", alt_rdata, 32'h2000 + 32'(i));
    end

    // User mode with bank select still 1
    write_sr(32'h20000000);
    check("R11", sr_rdata, 32'h20000000);
    for (int i = 0; i < 8; i++) begin
      gpr_idx = 3'(i);
      alt_idx = 3'(i);
      #1;
      check("R5", gpr_rdata, 32'h1000 + 32'(i));
      check("R6", alt_rdata, 32'h0);
    end
    alt_we = 1'b1;
    alt_idx = 3'd4;
    alt_wdata = 32'hDEAD;
    tick();
    alt_we = 1'b0;
    write_gpr(5, 32'h5555);
    sr_wr_en = 1'b1;
    sr_wdata = 32'h40000000;
    #1;
    check("R11", {31'd0, sr_priv_viol}, 32'd1);
    tick();
    sr_wr_en = 1'b0;
    #1;
    check("R11", sr_rdata, 32'h20000000);
    // Back to privileged through an entry event; bank 1 now active
    pulse_entry();
    check("R4", sr_rdata, 32'h70000000);
    gpr_idx = 3'd4;
    alt_idx = 3'd5;
    #1;
    check("R6", gpr_rdata, 32'h2004);
    check("R5", alt_rdata, 32'h5555);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule